// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the register side of a small serial port. A host reaches it over a 32-bit word-addressed bus with separate read and write strobes and one interrupt line. Received characters come in on a byte port with a valid strobe, and line breaks come in on a separate event strobe. Both are held in an eight-entry circular receive queue, which the host drains through the data register.

Host writes to the data register send the low byte out on a transmit port as a one-cycle pulse. That port never pushes back. Several read-only status words show the queue state: a line-status word, an extended status word with the fill level, and an interrupt-enable word. The receive and transmit interrupt enables are set by writing the identify register. Serial framing and baud timing are handled elsewhere.

Top module: `mini_uart_regs`

## Requirements
- R1: The register is chosen by `addr_i >> 2`, giving the word index. The indices in use are 1, 16, 17, 18, 21 and 25. Any other index reads 0, and writes to it change nothing that can be observed.
- R2: Index 1 always reads 1, and writes to it have no effect.
- R3: A received entry goes to slot (read position + count) mod 8. It is accepted only while count < 8, and `rx_ready_o` is high exactly then. Input that arrives while the queue is full is dropped.
- R4: Reading index 16 returns the entry at the read position. If the queue is not empty, the read also decrements count and advances the read position from 7 back to 0. If the queue is empty, the read returns the stale entry and changes no state.
- R5: Writing index 17 sets the receive enable from bit 1 and the transmit enable from bit 0. Reading index 17 returns {rx_en, tx_en} in bits 1:0.
- R6: Index 18 reads 0xC0, plus bit 0 if tx_en is set, or else bit 1 if rx_en is set and the queue is not empty. Writing index 18 with bit 0 set makes count 0. This clear takes priority over a receive push in the same cycle.
- R7: Index 21 reads 0x60, with bit 0 set when the queue holds data.
- R8: Index 25 reads 0x302. When the queue is not empty, bit 0 is also set and count appears in bits 19:16.
- R9: `irq_o` = (rx_en AND count != 0) OR tx_en.
- R10: A break stores 0x400, and a break wins over a byte strobed in the same cycle. Bytes are stored zero-extended. The data read returns the stored entry zero-extended to 32 bits.
- R11: A write to index 16 drives `tx_valid_o` high for exactly one cycle, in the cycle after the write, with `tx_data_o` equal to the low 8 bits written.
- R12: If an accepted push and a popping read happen in the same cycle, count stays the same, the new entry lands in the slot computed from the old pointers, and the read position advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (a data read pops the queue) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i and state |
| irq_o | output | 1 | Interrupt request |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid, one-cycle pulse |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_break_i | input | 1 | Line break event strobe |
| rx_ready_o | output | 1 | Queue can accept an entry |

## Verification
The hardest situations to reach are a full queue whose read position has already wrapped, and a push and pop landing in the same cycle at that boundary. Reaching them needs long runs of pushes and reads that the host and the line side must interleave. The bench first fills the queue to eight entries and overflows it. It then drains the queue past slot 7 and overlaps pushes with data reads. After that it runs a long random mix weighted toward receive strobes, with every output compared against a behavioural model on every clock. Empty reads after the wrap check that the stale entry is returned.

// File: rtl/muart_pkg.sv
package muart_pkg;
  localparam int unsigned DEPTH   = 8;
  localparam int unsigned PTR_W   = $clog2(DEPTH);
  localparam int unsigned CNT_W   = PTR_W + 1;
  localparam int unsigned ENTRY_W = 11;
  localparam int unsigned DATA_W  = 32;

  localparam logic [ENTRY_W-1:0] BREAK_CODE = 11'h400;

  localparam int unsigned IDX_ENABLE = 1;
  localparam int unsigned IDX_DATA   = 16;
  localparam int unsigned IDX_IDENT  = 17;
  localparam int unsigned IDX_IEN    = 18;
  localparam int unsigned IDX_LINE   = 21;
  localparam int unsigned IDX_STAT   = 25;

  localparam logic [DATA_W-1:0] IEN_BASE  = 32'h0000_00C0;
  localparam logic [DATA_W-1:0] LINE_BASE = 32'h0000_0060;
  localparam logic [DATA_W-1:0] STAT_BASE = 32'h0000_0302;
  localparam int unsigned       STAT_CNT_LSB = 16;
endpackage

// File: rtl/muart_rx_queue.sv
module muart_rx_queue
  import muart_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  parameter int unsigned WIDTH_P = ENTRY_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              push_i,
  input  logic [WIDTH_P-1:0]                push_data_i,
  input  logic                              pop_i,
  input  logic                              clr_i,
  output logic [WIDTH_P-1:0]                head_o,
  output logic [$clog2(DEPTH_P):0]          count_o,
  output logic                              not_full_o
);
  localparam int unsigned PW = $clog2(DEPTH_P);
  localparam int unsigned CW = PW + 1;

  logic [WIDTH_P-1:0] mem_q [DEPTH_P];
  logic [PW-1:0]      rd_pos_q;
  logic [CW-1:0]      cnt_q;
  logic [PW-1:0]      wr_slot;
  logic               push_ok, pop_ok;

  assign not_full_o = (cnt_q < CW'(DEPTH_P));
  assign push_ok    = push_i && !clr_i && not_full_o;
  assign pop_ok     = pop_i && !clr_i && (cnt_q != '0);
  assign wr_slot    = rd_pos_q + cnt_q[PW-1:0];
  assign head_o     = mem_q[rd_pos_q];
  assign count_o    = cnt_q;

  for (genvar g = 0; g < DEPTH_P; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (push_ok && wr_slot == PW'(g))   mem_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pos_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      if (pop_ok) rd_pos_q <= rd_pos_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH_P));
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_full_o && !pop_i && !clr_i) |=> (cnt_q == CW'(DEPTH_P)));
  p_empty_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == '0 && !push_i && !clr_i) |=> ($stable(rd_pos_q) && cnt_q == '0));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_push_pop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && pop_ok) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/muart_status.sv
module muart_status
  import muart_pkg::*;
(
  input  logic [5:0]         idx_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [ENTRY_W-1:0] head_i,
  input  logic               rx_en_i,
  input  logic               tx_en_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic non_empty;
  assign non_empty = (count_i != '0);
  assign irq_o     = (rx_en_i && non_empty) || tx_en_i;

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      6'(IDX_ENABLE): rdata_o = 32'd1;
      6'(IDX_DATA):   rdata_o = DATA_W'(head_i);
      6'(IDX_IDENT):  rdata_o = {30'd0, rx_en_i, tx_en_i};
      6'(IDX_IEN): begin
        rdata_o = IEN_BASE;
        if (tx_en_i)                     rdata_o[0] = 1'b1;
        else if (rx_en_i && non_empty)   rdata_o[1] = 1'b1;
      end
      6'(IDX_LINE):   rdata_o = LINE_BASE | DATA_W'(non_empty);
      6'(IDX_STAT): begin
        rdata_o = STAT_BASE;
        if (non_empty) begin
          rdata_o[0] = 1'b1;
          rdata_o[STAT_CNT_LSB +: CNT_W] = count_i;
        end
      end
      default:        rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
  import muart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_break_i,
  output logic              rx_ready_o
);
  logic [5:0]         idx;
  logic               rx_en_q, tx_en_q;
  logic [ENTRY_W-1:0] head, push_val;
  logic [CNT_W-1:0]   count;
  logic               wr_data, wr_ident, clr;

  assign idx      = addr_i[7:2];
  assign wr_data  = wr_i && idx == 6'(IDX_DATA);
  assign wr_ident = wr_i && idx == 6'(IDX_IDENT);
  assign clr      = wr_i && idx == 6'(IDX_IEN) && wdata_i[0];
  // break wins over a byte in the same cycle
  assign push_val = rx_break_i ? BREAK_CODE : ENTRY_W'(rx_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q    <= 1'b0;
      tx_en_q    <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      if (wr_ident) begin
        rx_en_q <= wdata_i[1];
        tx_en_q <= wdata_i[0];
      end
      tx_valid_o <= wr_data;
      if (wr_data) tx_data_o <= wdata_i[7:0];
    end
  end

  muart_rx_queue #(.DEPTH_P(DEPTH), .WIDTH_P(ENTRY_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i || rx_break_i),
    .push_data_i (push_val),
    .pop_i       (rd_i && idx == 6'(IDX_DATA)),
    .clr_i       (clr),
    .head_o      (head),
    .count_o     (count),
    .not_full_o  (rx_ready_o)
  );

  muart_status u_status (
    .idx_i   (idx),
    .count_i (count),
    .head_i  (head),
    .rx_en_i (rx_en_q),
    .tx_en_i (tx_en_q),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  p_tx_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (tx_valid_o && tx_data_o == $past(wdata_i[7:0])));
  p_tx_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_data) |=> !tx_valid_o);
  p_irq_tx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_q |-> irq_o);
  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_q && !rx_en_q) |-> !irq_o);
endmodule

// File: tb/mini_uart_regs_test.sv
module mini_uart_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, txv, rxr;
  logic [7:0]  txd;
  logic [7:0]  rxd = '0;
  logic        rxv = 1'b0, brk = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model
  int mem [8];
  int rpos = 0, cnt = 0;
  bit rxen = 0, txen = 0;
  bit exp_txv = 0;
  int exp_txd = 0;

  always #4 clk = ~clk;

  mini_uart_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tx_data_o(txd),
    .tx_valid_o(txv), .rx_data_i(rxd), .rx_valid_i(rxv),
    .rx_break_i(brk), .rx_ready_o(rxr));

  function automatic int model_read(int idx);
    int r;
    case (idx)
      1:  r = 1;
      16: r = mem[rpos];
      17: r = (rxen ? 2 : 0) | (txen ? 1 : 0);
      18: r = 'hC0 | (txen ? 1 : ((rxen && cnt != 0) ? 2 : 0));
      21: r = 'h60 | (cnt != 0 ? 1 : 0);
      25: r = 'h302 | (cnt != 0 ? (1 | (cnt << 16)) : 0);
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      1: return "R2"; 16: return "R4"; 17: return "R5"; 18: return "R6";
      21: return "R7"; 25: return "R8"; default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus/line cycle: drive, compare before the edge, then advance the model
  task automatic step(bit w, bit r, int a, int wd, bit v, int d, bit b);
    int idx, val, slot;
    bit clr, pushok, popok;
    @(negedge clk);
    wr = w; rd = r; addr = 8'(a); wdata = wd; rxv = v; rxd = 8'(d); brk = b;
    #1;
    idx = a >> 2;
    chk(tag_of(idx), rdata, 32'(model_read(idx)));
    chk("R9 irq", irq, (rxen && cnt != 0) || txen);
    chk("R3 rx_ready", rxr, cnt < 8);
    chk("R11 tx_valid", txv, exp_txv);
    if (exp_txv) chk("R11 tx_data", txd, exp_txd);
    // next state
    exp_txv = w && idx == 16;
    if (exp_txv) exp_txd = wd & 'hFF;
    if (w && idx == 17) begin rxen = wd[1]; txen = wd[0]; end
    clr = w && idx == 18 && wd[0];
    val = b ? 'h400 : (d & 'hFF);   // R10
    if (clr) cnt = 0;
    else begin
      pushok = (v || b) && cnt < 8;
      popok  = r && idx == 16 && cnt > 0;
      if (pushok) begin slot = (rpos + cnt) % 8; mem[slot] = val; end
      if (popok) rpos = (rpos + 1) % 8;
      cnt = cnt + int'(pushok) - int'(popok);
    end
    @(posedge clk);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wreg(int i, int d); step(1, 0, i*4, d, 0, 0, 0); endtask
  task automatic rreg(int i); step(0, 1, i*4, 0, 0, 0, 0); endtask
  task automatic rx(int d); step(0, 0, 0, 0, 1, d, 0); endtask

  initial begin
    #(8*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (mem[i]) mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state, every register index (R1 R2 R5 R6 R7 R8)
    for (int i = 0; i < 64; i++) step(0, 0, i*4, 0, 0, 0, 0);
    rreg(16);                          // R4 empty read, stale zero
    wreg(1, 0); rreg(1);               // R2 write ignored
    wreg(3, 'hFF); wreg(40, 3); rreg(17); rreg(3); // R1 stray writes ignored
    wreg(17, 2); rreg(17); rreg(18);   // R5 rx enable
    // fill to full and overflow (R3)
    for (int i = 0; i < 10; i++) rx('hA0 + i);
    rreg(25); rreg(21); rreg(18);      // R8 count 8
    step(0, 0, 0, 0, 1, 'h55, 1);      // full: break dropped
    for (int i = 0; i < 5; i++) rreg(16);  // R4 pops
    step(0, 0, 0, 0, 0, 0, 1);         // R10 break
    step(0, 0, 0, 0, 1, 'h33, 1);      // R10 break wins
    // R12 simultaneous push and pop around the wrap
    for (int i = 0; i < 12; i++) step(0, 1, 64, 0, 1, 'hC0 + i, 0);
    for (int i = 0; i < 9; i++) rreg(16);
    rreg(16); rreg(16);                // R4 empty stale read after wrap
    // R11 transmit
    wreg(16, 'h1234_5678); wreg(16, 'h9A); idle(); idle();
    wreg(17, 1); rreg(18);             // R9 tx enable irq
    // R6 clear, with a colliding push
    rx(1); rx(2); wreg(17, 2); rreg(18);
    step(1, 0, 72, 1, 1, 'h77, 0); rreg(25); wreg(18, 2); rreg(21);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k, ix;
      k = $urandom_range(0, 9);
      ix = (k < 6) ? 16 : int'($urandom_range(0, 31));
      step(k == 7 && $urandom_range(0, 3) == 0, k < 5 || k == 8, ix*4,
           $urandom, $urandom_range(0, 1), $urandom_range(0, 255),
           $urandom_range(0, 15) == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule